// File: doc/BRIEF.md
# Low-Frequency Interval Timer

This block is a free-running 14-bit interval counter meant for timekeeping. Each clock cycle it advances by one when the chosen count-enable input is high. There are three such inputs: a slow crystal tick, the system cycle enable, and a tick from a prescaler outside the block. A two-bit selector picks which input counts.

The block produces two events. The first is a long-period event when the full counter wraps, which is 16384 counts (half a second on a 32.768 kHz tick). The second is a short-interval event taken from one of four divider taps, at 32, 128, 512 or 2048 counts. Each event gives a one-cycle pulse and sets a sticky flag. Each flag has its own interrupt enable, and a single interrupt request combines the enabled flags.

Clearing the run input, or changing the source selector, sends the counter back to zero. This keeps a partial interval from being reported. The reset input is asynchronous and active low, and the block releases it inside on the clock through a two-stage synchronizer.

Top module: `lf_interval_timer`

## Requirements
- R1: The counter is 14 bits wide. `ovf_pulse` goes high once for every 16384 counts of the selected source, counted from zero.
- R2: `ivl_pulse` goes high once every 32, 128, 512 or 2048 counts, for `ivl_sel` = 0, 1, 2 and 3. Every overflow is also an interval event.
- R3: The `src_sel` encoding is 0 = crystal tick, 1 = system tick, 2 = external prescaler tick, 3 = no source (the counter holds). Ticks on inputs that are not selected have no effect.
- R4: A pulse lasts exactly one cycle. It is high in the cycle after the clock edge at which the counting tick was sampled.
- R5: An event sets its sticky flag. A high clear strobe clears the flag at the next edge. When an event and a clear come in the same cycle, the event wins.
- R6: `irq` is high exactly when at least one flag is set and its enable is high.
- R7: While `run` is low, the counter is held at zero and no pulse occurs.
- R8: In any cycle where `src_sel` differs from its value in the previous cycle, the counter is cleared and does not count.
- R9: Changing `ivl_sel` does not clear the counter. The newly chosen tap fires when the running count reaches its next multiple of that tap's period.
- R10: After reset, all pulses, flags and `irq` are low, and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | Count enable from the slow crystal domain (source 0) |
| sys_tick | input | 1 | System cycle count enable (source 1) |
| pre_tick | input | 1 | External prescaler count enable (source 2) |
| src_sel | input | 2 | Count source selector |
| ivl_sel | input | 2 | Short-interval tap selector |
| run | input | 1 | Count enable; low clears the counter |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| ivl_clr | input | 1 | Clear strobe for the interval flag |
| ovf_ie | input | 1 | Interrupt enable for the overflow flag |
| ivl_ie | input | 1 | Interrupt enable for the interval flag |
| ovf_pulse | output | 1 | One-cycle overflow event |
| ivl_pulse | output | 1 | One-cycle interval event |
| ovf_flag | output | 1 | Sticky overflow flag |
| ivl_flag | output | 1 | Sticky interval flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench runs every tap setting and every count source, with noise on the inputs that are not selected. It also runs a full wrap of the counter with sparse ticks, so an off-by-one tap width or a missed carry shows up as a pulse one period early or late. It switches the source in the middle of an interval and drops `run`, so a design that kept the partial count would fire before a full period had passed. It changes `ivl_sel` in the middle of a count, puts a clear strobe in the same cycle as an event, and toggles the enables while flags are set. A design that gave the clear priority, or gated the flags rather than the request, would then show a wrong flag or `irq` value.

// File: rtl/lft_pkg.sv
`timescale 1ns/1ps
package lft_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_PRE  = 2'd2,
    SRC_NONE = 2'd3
  } lft_src_e;
endpackage

// File: rtl/lft_tick_mux.sv
`timescale 1ns/1ps
module lft_tick_mux
  import lft_pkg::*;
(
  input  logic       xtal_tick,
  input  logic       sys_tick,
  input  logic       pre_tick,
  input  logic [1:0] src_sel,
  output logic       tick
);
  always_comb begin
    unique case (lft_src_e'(src_sel))
      SRC_XTAL: tick = xtal_tick;
      SRC_SYS:  tick = sys_tick;
      SRC_PRE:  tick = pre_tick;
      default:  tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/lft_counter.sv
`timescale 1ns/1ps
module lft_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [1:0]       src_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             step
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       src_q;
  logic             src_chg;

  assign src_chg = (src_sel != src_q);
  assign step    = run & tick & ~src_chg;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || src_chg) cnt_d = '0;
    else if (tick)       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= 2'd0;
    end else begin
      cnt_q <= cnt_d;
      src_q <= src_sel;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lft_tap_detect.sv
`timescale 1ns/1ps
module lft_tap_detect #(
  parameter int CNT_W     = 14,
  parameter int SEL_W     = 2,
  parameter int TAP_BASE  = 5,
  parameter int TAP_STEP  = 2
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             step,
  input  logic [SEL_W-1:0] ivl_sel,
  output logic             ovf_hit,
  output logic             ivl_hit
);
  localparam int NUM_TAPS = 1 << SEL_W;

  logic [NUM_TAPS-1:0] tap_full;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int TW = TAP_BASE + TAP_STEP * i;
    assign tap_full[i] = &cnt[TW-1:0];
  end

  assign ovf_hit = step & (&cnt);
  assign ivl_hit = step & tap_full[ivl_sel];
endmodule

// File: rtl/lft_event_flag.sv
`timescale 1ns/1ps
module lft_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic ie,
  output logic pulse,
  output logic flag,
  output logic req
);
  logic pulse_q, flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= hit;
      flag_q  <= flag_d;
    end
  end

  assign pulse = pulse_q;
  assign flag  = flag_q;
  assign req   = flag_q & ie;
endmodule

// File: rtl/lf_interval_timer.sv
`timescale 1ns/1ps
module lf_interval_timer #(
  parameter int CNT_W     = 14,
  parameter int IVL_SEL_W = 2,
  parameter int TAP_BASE  = 5,
  parameter int TAP_STEP  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xtal_tick,
  input  logic                 sys_tick,
  input  logic                 pre_tick,
  input  logic [1:0]           src_sel,
  input  logic [IVL_SEL_W-1:0] ivl_sel,
  input  logic                 run,
  input  logic                 ovf_clr,
  input  logic                 ivl_clr,
  input  logic                 ovf_ie,
  input  logic                 ivl_ie,
  output logic                 ovf_pulse,
  output logic                 ivl_pulse,
  output logic                 ovf_flag,
  output logic                 ivl_flag,
  output logic                 irq
);
  localparam int NUM_EV = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_n_sync;
  logic             tick, step;
  logic [CNT_W-1:0] cnt;
  logic [NUM_EV-1:0] ev_hit, ev_clr, ev_ie, ev_pulse, ev_flag, ev_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  lft_tick_mux u_mux (
    .xtal_tick (xtal_tick),
    .sys_tick  (sys_tick),
    .pre_tick  (pre_tick),
    .src_sel   (src_sel),
    .tick      (tick)
  );

  lft_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .tick    (tick),
    .run     (run),
    .src_sel (src_sel),
    .cnt     (cnt),
    .step    (step)
  );

  lft_tap_detect #(
    .CNT_W    (CNT_W),
    .SEL_W    (IVL_SEL_W),
    .TAP_BASE (TAP_BASE),
    .TAP_STEP (TAP_STEP)
  ) u_tap (
    .cnt     (cnt),
    .step    (step),
    .ivl_sel (ivl_sel),
    .ovf_hit (ev_hit[0]),
    .ivl_hit (ev_hit[1])
  );

  assign ev_clr = {ivl_clr, ovf_clr};
  assign ev_ie  = {ivl_ie, ovf_ie};

  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    lft_event_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .hit   (ev_hit[e]),
      .clr   (ev_clr[e]),
      .ie    (ev_ie[e]),
      .pulse (ev_pulse[e]),
      .flag  (ev_flag[e]),
      .req   (ev_req[e])
    );
  end

  assign ovf_pulse = ev_pulse[0];
  assign ivl_pulse = ev_pulse[1];
  assign ovf_flag  = ev_flag[0];
  assign ivl_flag  = ev_flag[1];
  assign irq       = |ev_req;
endmodule

// File: rtl/lft_checker.sv
`timescale 1ns/1ps
module lft_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [1:0] src_sel,
  input logic       ovf_clr,
  input logic       ivl_clr,
  input logic       ovf_pulse,
  input logic       ivl_pulse,
  input logic       ovf_flag,
  input logic       ivl_flag,
  input logic       irq
);
  // R2
  ovf_implies_ivl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ivl_pulse);
  // R4
  ovf_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);
  // R5
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_flag);
  // R5
  ivl_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_pulse |-> ivl_flag);
  // R5
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_clr) && !ovf_pulse) |-> !ovf_flag);
  // R5
  ivl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ivl_clr) && !ivl_pulse) |-> !ivl_flag);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag || ivl_flag));
  // R7
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ovf_pulse && !ivl_pulse));
  // R8
  src_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |=> !ivl_pulse);
endmodule

bind lf_interval_timer lft_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .run       (run),
  .src_sel   (src_sel),
  .ovf_clr   (ovf_clr),
  .ivl_clr   (ivl_clr),
  .ovf_pulse (ovf_pulse),
  .ivl_pulse (ivl_pulse),
  .ovf_flag  (ovf_flag),
  .ivl_flag  (ivl_flag),
  .irq       (irq)
);

// File: tb/lf_interval_timer_tb.sv
`timescale 1ns/1ps
module lf_interval_timer_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic xtal_tick, sys_tick, pre_tick;
  logic [1:0] src_sel, ivl_sel;
  logic run, ovf_clr, ivl_clr, ovf_ie, ivl_ie;
  logic ovf_pulse, ivl_pulse, ovf_flag, ivl_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R10";

  // bench model state
  logic [1:0] m_prev_src = 2'd0;
  int  m_n = 0;
  logic m_of = 0, m_if = 0;

  always #2 clk = ~clk;

  lf_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .sys_tick(sys_tick),
    .pre_tick(pre_tick), .src_sel(src_sel), .ivl_sel(ivl_sel), .run(run),
    .ovf_clr(ovf_clr), .ivl_clr(ivl_clr), .ovf_ie(ovf_ie), .ivl_ie(ivl_ie),
    .ovf_pulse(ovf_pulse), .ivl_pulse(ivl_pulse), .ovf_flag(ovf_flag),
    .ivl_flag(ivl_flag), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s act=%0b exp=%0b t=%0t", tag, phase, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic xt, input logic st, input logic pt);
    logic chg, sel_tick, active, e_ovf, e_ivl, e_irq;
    int per;
    @(negedge clk);
    xtal_tick = xt; sys_tick = st; pre_tick = pt;
    chg = (src_sel != m_prev_src);
    m_prev_src = src_sel;
    case (src_sel)
      2'd0: sel_tick = xt;
      2'd1: sel_tick = st;
      2'd2: sel_tick = pt;
      default: sel_tick = 1'b0;
    endcase
    active = run && sel_tick && !chg;
    if (!run || chg) m_n = 0;
    else if (active) m_n = (m_n + 1) % 16384;
    per   = 32 << (2 * ivl_sel);
    e_ivl = active && (m_n % per == 0);
    e_ovf = active && (m_n == 0);
    m_of  = (m_of && !ovf_clr) || e_ovf;
    m_if  = (m_if && !ivl_clr) || e_ivl;
    e_irq = (m_of && ovf_ie) || (m_if && ivl_ie);
    @(posedge clk);
    #1;
    chk("R1", "ovf_pulse", ovf_pulse, e_ovf);
    chk("R2", "ivl_pulse", ivl_pulse, e_ivl);
    chk("R5", "ovf_flag", ovf_flag, m_of);
    chk("R5", "ivl_flag", ivl_flag, m_if);
    chk("R6", "irq", irq, e_irq);
  endtask

  initial begin
    rst_n = 0; xtal_tick = 0; sys_tick = 0; pre_tick = 0;
    src_sel = 0; ivl_sel = 0; run = 0;
    ovf_clr = 0; ivl_clr = 0; ovf_ie = 0; ivl_ie = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", "ovf_pulse", ovf_pulse, 1'b0);
    chk("R10", "ivl_pulse", ivl_pulse, 1'b0);
    chk("R10", "ovf_flag", ovf_flag, 1'b0);
    chk("R10", "ivl_flag", ivl_flag, 1'b0);
    chk("R10", "irq", irq, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (4) step(0, 0, 0);

    // R2/R3/R4: every tap, crystal source, noise on other inputs
    phase = "R2"; ovf_ie = 1; ivl_ie = 1;
    for (int s = 0; s < 4; s++) begin
      ivl_sel = 2'(s); run = 0; step(1, 1, 1); run = 1;
      for (int i = 0; i < 4200; i++) begin
        ivl_clr = (i % 1000 == 999);
        step(1, (i % 3) == 0, (i % 2) == 0);
      end
      ivl_clr = 0;
    end

    // R1: full wrap on system tick with gaps
    phase = "R1"; src_sel = 2'd1; ivl_sel = 2'd3; ivl_ie = 0;
    ovf_clr = 1; step(1, 0, 1); ovf_clr = 0;
    for (int i = 0; i < 33000; i++) begin
      ovf_clr = (i == 20000);
      step((i % 5) == 0, (i % 2) == 0, 1);
    end
    ovf_clr = 0;

    // R3: prescaler source then the no-source setting
    phase = "R3"; src_sel = 2'd2; ivl_sel = 2'd2;
    for (int i = 0; i < 22000; i++) step(1, 1, (i % 4) != 3);
    src_sel = 2'd3;
    for (int i = 0; i < 300; i++) step(1, 1, 1);

    // R8: source change mid interval discards partial count
    phase = "R8"; src_sel = 2'd0; ivl_sel = 2'd0;
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    src_sel = 2'd1;
    for (int i = 0; i < 70; i++) step(0, 1, 0);

    // R7: run low mid interval
    phase = "R7";
    for (int i = 0; i < 10; i++) step(0, 1, 0);
    run = 0;
    for (int i = 0; i < 5; i++) step(1, 1, 1);
    run = 1;
    for (int i = 0; i < 70; i++) step(0, 1, 0);

    // R9: interval select change keeps count
    phase = "R9"; ivl_sel = 2'd0;
    for (int i = 0; i < 40; i++) step(0, 1, 0);
    ivl_sel = 2'd1;
    for (int i = 0; i < 200; i++) step(0, 1, 0);
    ivl_sel = 2'd0;
    for (int i = 0; i < 50; i++) step(0, 1, 0);

    // R5/R6: clear vs event collision and enable toggling
    phase = "R5"; ivl_sel = 2'd0;
    for (int i = 0; i < 200; i++) begin
      ivl_clr = (i % 32 == 31) || (i % 7 == 0);
      step(0, 1, 0);
    end
    ivl_clr = 0;
    phase = "R6";
    for (int k = 0; k < 4; k++) begin
      ovf_ie = k[0]; ivl_ie = k[1];
      step(0, 0, 0);
      step(0, 0, 0);
    end
    ovf_clr = 1; ivl_clr = 1; step(0, 0, 0);
    ovf_clr = 0; ivl_clr = 0; step(0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog expired act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule